// File: doc/BRIEF.md
# Rectangular Block Transfer Engine

This engine copies a rectangle of 8-bit colour-index pixels from one place in a word-addressed video memory to another. Every memory word is 16 bits wide and holds two pixels, one per byte lane. The lower lane (bits 7:0) is the left pixel. The source and the destination each have their own address generator. Each generator is set either to linear layout, where consecutive words follow one another, or to rectangular layout, where every row begins one line stride after the start of the row before it. This lets off-screen data be packed tightly while on-screen data follows the display pitch.

Each destination word is produced from the source word by one of four raster operations: plain copy, copy with colour index 0 as a transparency key, exclusive-or with the existing destination word, or exclusive-or with the key. A monochrome expansion option reads 1-bit source data and turns each bit into one of two programmed colours. In that case one source word supplies sixteen pixels, which is eight destination words. Byte-lane enables trim the first and last word of every row, so a rectangle does not have to start or end on a word boundary.

The configuration inputs are sampled on a start pulse. The engine then issues memory requests one at a time over a request/ready handshake. When the rectangle is complete it raises a done flag.

Top module: `blt_engine`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are all 0.
- R2: A walker in linear layout (`cfg_*_rect`=0) advances one word for each transfer. With a linear destination, word c of row r goes to base + r*width + c.
- R3: A walker in rectangular layout (`cfg_*_rect`=1) places word c of row r at base + r*stride + c. It moves to the next row after `cfg_width` words.
- R4: In the first word of each row, `mem_be` is ANDed with `cfg_first_be`. In the last word of each row it is ANDed with `cfg_last_be`. When the width is 1, both apply. `mem_be` bit 0 enables bits 7:0 and bit 1 enables bits 15:8.
- R5: With `cfg_rop`=0 (copy), each destination word receives the source word unchanged.
- R6: With `cfg_rop`=1 (key), any lane whose source pixel is 0 has its byte enable cleared. The destination byte in that lane keeps its old value.
- R7: With `cfg_rop`=2 (xor), each destination word is read first and then written at the same address with source XOR destination. That is two memory transactions per word.
- R8: With `cfg_rop`=3, the xor behaviour of R7 is combined with the index-0 key of R6. The key is applied to the source pixel.
- R9: With `cfg_expand`=1, destination word k of each group of eight takes source bit 2k for lane 0 and bit 2k+1 for lane 1. A bit value of 1 selects `cfg_color1` and 0 selects `cfg_color0`. One source word is read for every eight destination words, and each row starts on a fresh source word.
- R10: `busy` is 1 from the cycle after an accepted start until the last write is accepted. In the next cycle `busy` is 0 and `done` is 1. `done` stays set until the next start, which clears it. A request is only made while busy.
- R11: While `mem_req` is high and `mem_ready` is low, the address, direction, byte enables and write data stay unchanged.
- R12: A start with zero width or zero height sets `done` in the next cycle without issuing any memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, taken only while idle |
| cfg_src_base | input | AW | Source start word address |
| cfg_dst_base | input | AW | Destination start word address |
| cfg_src_stride | input | AW | Source line pitch in words (rectangular layout) |
| cfg_dst_stride | input | AW | Destination line pitch in words (rectangular layout) |
| cfg_src_rect | input | 1 | Source layout: 1 rectangular, 0 linear |
| cfg_dst_rect | input | 1 | Destination layout: 1 rectangular, 0 linear |
| cfg_width | input | DIM_W | Destination words per row |
| cfg_height | input | DIM_W | Number of rows |
| cfg_rop | input | 2 | Raster operation: 0 copy, 1 key, 2 xor, 3 xor with key |
| cfg_expand | input | 1 | Treat the source as 1 bit per pixel |
| cfg_color0 | input | 8 | Colour for a 0 bit in expansion |
| cfg_color1 | input | 8 | Colour for a 1 bit in expansion |
| cfg_first_be | input | 2 | Lane enables for the first word of a row |
| cfg_last_be | input | 2 | Lane enables for the last word of a row |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer complete |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Word address |
| mem_be | output | 2 | Byte-lane write enables |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid when a read is accepted |
| mem_ready | input | 1 | Memory accepts the current request |

## Verification
The assertions check these on every cycle:
- requests stay stable through a stall;
- requests appear only while busy, and done never coincides with busy;
- done rises only after a final write or a start;
- every xor write follows a read of the same address;
- under the plain key operation, a zero pixel lane is never enabled.

The address sequences of both layouts, the edge trimming, the exact merged memory contents, the expansion bit order, the one-read-per-eight-words economy and the zero-size shortcut depend on the whole transfer. Only the bench's scenarios can show them, by comparing the final memory with an independent model and counting reads and writes.

// File: rtl/blt_pkg.sv
package blt_pkg;
  localparam int PIX_W  = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = PIX_W * LANES;
  localparam int GRP_W  = 3;   // eight destination words per 1-bit source word

  typedef enum logic [1:0] {
    ROP_COPY    = 2'd0,
    ROP_KEY     = 2'd1,
    ROP_XOR     = 2'd2,
    ROP_XOR_KEY = 2'd3
  } rop_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SRC,
    ST_DST,
    ST_WR
  } st_e;

  // colour chosen by one bit of a monochrome source word
  function automatic logic [PIX_W-1:0] mono_pix(
    input logic [WORD_W-1:0] w,
    input logic [GRP_W-1:0]  grp,
    input logic              lane,
    input logic [PIX_W-1:0]  c0,
    input logic [PIX_W-1:0]  c1
  );
    logic [GRP_W:0] idx;
    idx = {grp, lane};
    return w[idx] ? c1 : c0;
  endfunction

  // lane enables from the row edge position
  function automatic logic [LANES-1:0] edge_mask(
    input logic             first,
    input logic             last,
    input logic [LANES-1:0] fbe,
    input logic [LANES-1:0] lbe
  );
    logic [LANES-1:0] m;
    m = '1;
    if (first) m = m & fbe;
    if (last)  m = m & lbe;
    return m;
  endfunction

  function automatic logic rop_has_xor(input rop_e r);
    return (r == ROP_XOR) || (r == ROP_XOR_KEY);
  endfunction

  function automatic logic rop_has_key(input rop_e r);
    return (r == ROP_KEY) || (r == ROP_XOR_KEY);
  endfunction
endpackage

// File: rtl/blt_addr_walk.sv
module blt_addr_walk #(
  parameter int AW    = 24,
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    base,
  input  logic             rect,
  input  logic [DIM_W-1:0] width,
  input  logic [AW-1:0]    stride,
  input  logic             step,
  output logic [AW-1:0]    addr
);
  logic [AW-1:0]    addr_q;
  logic [AW-1:0]    row_q;
  logic [AW-1:0]    stride_q;
  logic [DIM_W-1:0] col_q;
  logic [DIM_W-1:0] width_q;
  logic             rect_q;
  logic             row_end;

  assign row_end = (col_q == width_q - 1'b1);
  assign addr    = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      row_q    <= '0;
      stride_q <= '0;
      col_q    <= '0;
      width_q  <= '0;
      rect_q   <= 1'b0;
    end else if (load) begin
      addr_q   <= base;
      row_q    <= base;
      stride_q <= stride;
      col_q    <= '0;
      width_q  <= width;
      rect_q   <= rect;
    end else if (step) begin
      if (rect_q && row_end) begin
        row_q  <= row_q + stride_q;
        addr_q <= row_q + stride_q;
        col_q  <= '0;
      end else begin
        addr_q <= addr_q + 1'b1;
        col_q  <= row_end ? '0 : col_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/blt_pixel_op.sv
module blt_pixel_op
  import blt_pkg::*;
(
  input  logic [WORD_W-1:0] src_word,
  input  logic [WORD_W-1:0] dst_word,
  input  logic [GRP_W-1:0]  grp,
  input  logic              expand,
  input  logic              xor_mode,
  input  logic              key_mode,
  input  logic [PIX_W-1:0]  color0,
  input  logic [PIX_W-1:0]  color1,
  input  logic [LANES-1:0]  edge_be,
  output logic [WORD_W-1:0] wdata,
  output logic [LANES-1:0]  be
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [PIX_W-1:0] s_pix;
    logic [PIX_W-1:0] d_pix;
    logic             keyed;

    assign d_pix = dst_word[g*PIX_W +: PIX_W];
    assign s_pix = expand ? mono_pix(src_word, grp, 1'(g), color0, color1)
                          : src_word[g*PIX_W +: PIX_W];
    assign keyed = key_mode && (s_pix == '0);
    assign wdata[g*PIX_W +: PIX_W] = xor_mode ? (s_pix ^ d_pix) : s_pix;
    assign be[g] = edge_be[g] && !keyed;
  end
endmodule

// File: rtl/blt_engine.sv
module blt_engine
  import blt_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    cfg_src_base,
  input  logic [AW-1:0]    cfg_dst_base,
  input  logic [AW-1:0]    cfg_src_stride,
  input  logic [AW-1:0]    cfg_dst_stride,
  input  logic             cfg_src_rect,
  input  logic             cfg_dst_rect,
  input  logic [DIM_W-1:0] cfg_width,
  input  logic [DIM_W-1:0] cfg_height,
  input  logic [1:0]       cfg_rop,
  input  logic             cfg_expand,
  input  logic [7:0]       cfg_color0,
  input  logic [7:0]       cfg_color1,
  input  logic [1:0]       cfg_first_be,
  input  logic [1:0]       cfg_last_be,
  output logic             busy,
  output logic             done,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [1:0]       mem_be,
  output logic [15:0]      mem_wdata,
  input  logic [15:0]      mem_rdata,
  input  logic             mem_ready
);
  localparam int EXT_W = DIM_W + 1;

  st_e              state;
  rop_e             rop_q;
  logic             expand_q;
  logic [PIX_W-1:0] c0_q, c1_q;
  logic [LANES-1:0] fbe_q, lbe_q;
  logic [DIM_W-1:0] width_q, height_q;
  logic [DIM_W-1:0] col_q, row_q;
  logic [WORD_W-1:0] src_q, dst_q;
  logic             done_q;

  // named internal events
  logic             start_go, zero_size, load_walk;
  logic             accept, rd_src_fire, rd_dst_fire, wr_fire;
  logic             col_last, row_last, last_word;
  logic             xor_mode, key_mode;
  logic [DIM_W-1:0] col_nxt;
  logic             need_src;
  logic [EXT_W-1:0] w_ext;
  logic [DIM_W-1:0] src_width;
  logic [LANES-1:0] edge_be;
  logic [AW-1:0]    src_addr, dst_addr;
  logic [WORD_W-1:0] op_wdata;
  logic [LANES-1:0] op_be;

  assign zero_size = (cfg_width == '0) || (cfg_height == '0);
  assign start_go  = start && (state == ST_IDLE);
  assign load_walk = start_go && !zero_size;

  // words of 1-bit source per row: ceil(width / 8)
  assign w_ext     = {1'b0, cfg_width} + EXT_W'(7);
  assign src_width = cfg_expand ? {{GRP_W-1{1'b0}}, w_ext[EXT_W-1:GRP_W]} : cfg_width;

  assign accept      = mem_req && mem_ready;
  assign rd_src_fire = accept && (state == ST_SRC);
  assign rd_dst_fire = accept && (state == ST_DST);
  assign wr_fire     = accept && (state == ST_WR);

  assign col_last  = (col_q == width_q - 1'b1);
  assign row_last  = (row_q == height_q - 1'b1);
  assign last_word = col_last && row_last;
  assign col_nxt   = col_last ? '0 : col_q + 1'b1;
  assign need_src  = !expand_q || (col_nxt[GRP_W-1:0] == '0);

  assign xor_mode = rop_has_xor(rop_q);
  assign key_mode = rop_has_key(rop_q);
  assign edge_be  = edge_mask(col_q == '0, col_last, fbe_q, lbe_q);

  blt_addr_walk #(.AW(AW), .DIM_W(DIM_W)) u_src_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_walk),
    .base   (cfg_src_base),
    .rect   (cfg_src_rect),
    .width  (src_width),
    .stride (cfg_src_stride),
    .step   (rd_src_fire),
    .addr   (src_addr)
  );

  blt_addr_walk #(.AW(AW), .DIM_W(DIM_W)) u_dst_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_walk),
    .base   (cfg_dst_base),
    .rect   (cfg_dst_rect),
    .width  (cfg_width),
    .stride (cfg_dst_stride),
    .step   (wr_fire),
    .addr   (dst_addr)
  );

  blt_pixel_op u_op (
    .src_word (src_q),
    .dst_word (dst_q),
    .grp      (col_q[GRP_W-1:0]),
    .expand   (expand_q),
    .xor_mode (xor_mode),
    .key_mode (key_mode),
    .color0   (c0_q),
    .color1   (c1_q),
    .edge_be  (edge_be),
    .wdata    (op_wdata),
    .be       (op_be)
  );

  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign mem_req   = (state != ST_IDLE);
  assign mem_we    = (state == ST_WR);
  assign mem_addr  = (state == ST_SRC) ? src_addr : dst_addr;
  assign mem_be    = (state == ST_WR) ? op_be : '0;
  assign mem_wdata = op_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      done_q   <= 1'b0;
      rop_q    <= ROP_COPY;
      expand_q <= 1'b0;
      c0_q     <= '0;
      c1_q     <= '0;
      fbe_q    <= '0;
      lbe_q    <= '0;
      width_q  <= '0;
      height_q <= '0;
      col_q    <= '0;
      row_q    <= '0;
      src_q    <= '0;
      dst_q    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_go) begin
            rop_q    <= rop_e'(cfg_rop);
            expand_q <= cfg_expand;
            c0_q     <= cfg_color0;
            c1_q     <= cfg_color1;
            fbe_q    <= cfg_first_be;
            lbe_q    <= cfg_last_be;
            width_q  <= cfg_width;
            height_q <= cfg_height;
            col_q    <= '0;
            row_q    <= '0;
            if (zero_size) begin
              done_q <= 1'b1;
            end else begin
              done_q <= 1'b0;
              state  <= ST_SRC;
            end
          end
        end
        ST_SRC: begin
          if (rd_src_fire) begin
            src_q <= mem_rdata;
            state <= xor_mode ? ST_DST : ST_WR;
          end
        end
        ST_DST: begin
          if (rd_dst_fire) begin
            dst_q <= mem_rdata;
            state <= ST_WR;
          end
        end
        ST_WR: begin
          if (wr_fire) begin
            if (last_word) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              col_q <= col_nxt;
              if (col_last) row_q <= row_q + 1'b1;
              if (need_src)      state <= ST_SRC;
              else if (xor_mode) state <= ST_DST;
              else               state <= ST_WR;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blt_engine_chk.sv
module blt_engine_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_be,
  input logic [15:0]   mem_wdata,
  input logic          wr_fire,
  input logic          last_word,
  input logic          xor_mode,
  input logic          key_mode
);
  logic          prev_rd;
  logic [AW-1:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rd   <= 1'b0;
      prev_addr <= '0;
    end else if (mem_req && mem_ready) begin
      prev_rd   <= !mem_we;
      prev_addr <= mem_addr;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_be) && $stable(mem_wdata)); // R11

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R10

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_fire && last_word) || $past(start)); // R10

  AST_XOR_PREREAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && xor_mode |-> prev_rd && (prev_addr == mem_addr)); // R7

  AST_KEY_CLEARS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && key_mode && !xor_mode && (mem_wdata[7:0] == 8'h00) |-> !mem_be[0]); // R6
endmodule

bind blt_engine blt_engine_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .wr_fire   (wr_fire),
  .last_word (last_word),
  .xor_mode  (xor_mode),
  .key_mode  (key_mode)
);

// File: tb/tb_blt_engine.sv
module tb_blt_engine;
  localparam int AW = 24;
  localparam int DW = 12;
  localparam int MEMN = 1024;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start;
  logic [AW-1:0] src_base, dst_base, src_stride, dst_stride;
  logic src_rect, dst_rect, expand;
  logic [DW-1:0] width, height;
  logic [1:0] rop, fbe, lbe;
  logic [7:0] col0, col1;
  logic busy, done, mem_req, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_be;
  logic [15:0] mem_wdata, mem_rdata;

  logic [15:0] tb_mem [0:MEMN-1];
  logic [15:0] exp_mem [0:MEMN-1];

  int cyc = 0, last_wr_cyc = 0, n_rd = 0, n_wr = 0, stall_err = 0;
  int n_checks = 0, n_bad = 0;
  bit finished = 0;
  logic p_stall = 0, p_we = 0;
  logic [AW-1:0] p_addr = '0;
  logic [1:0] p_be = '0;
  logic [15:0] p_wd = '0;

  blt_engine #(.AW(AW), .DIM_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src_base(src_base), .cfg_dst_base(dst_base),
    .cfg_src_stride(src_stride), .cfg_dst_stride(dst_stride),
    .cfg_src_rect(src_rect), .cfg_dst_rect(dst_rect),
    .cfg_width(width), .cfg_height(height), .cfg_rop(rop),
    .cfg_expand(expand), .cfg_color0(col0), .cfg_color1(col1),
    .cfg_first_be(fbe), .cfg_last_be(lbe),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  assign mem_rdata = tb_mem[mem_addr[9:0]];

  // memory model, transaction counters and stall monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        if (mem_be[0]) tb_mem[mem_addr[9:0]][7:0]  <= mem_wdata[7:0];
        if (mem_be[1]) tb_mem[mem_addr[9:0]][15:8] <= mem_wdata[15:8];
        n_wr <= n_wr + 1;
        last_wr_cyc <= cyc;
      end else begin
        n_rd <= n_rd + 1;
      end
    end
    if (p_stall && (!mem_req || mem_addr != p_addr || mem_we != p_we ||
                    (p_we && (mem_be != p_be || mem_wdata != p_wd))))
      stall_err <= stall_err + 1;
    p_stall <= mem_req && !mem_ready;
    p_addr <= mem_addr; p_we <= mem_we; p_be <= mem_be; p_wd <= mem_wdata;
  end

  always @(negedge clk) mem_ready <= (cyc % 3) != 2;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] init_val(input int i);
    logic [7:0] lo, hi;
    lo = (i % 3 == 0) ? 8'h00 : 8'(i * 7 + 1);
    hi = (i % 4 == 1) ? 8'h00 : 8'(i * 5 + 3);
    return {hi, lo};
  endfunction

  task automatic mem_init();
    for (int i = 0; i < MEMN; i++) begin
      tb_mem[i] = init_val(i);
      exp_mem[i] = init_val(i);
    end
  endtask

  // independent restatement of the transfer on exp_mem
  task automatic model();
    int sw;
    sw = (int'(width) + 7) / 8;
    for (int r = 0; r < int'(height); r++) begin
      for (int c = 0; c < int'(width); c++) begin
        int da, sa;
        logic [15:0] s, d;
        da = dst_rect ? int'(dst_base) + r * int'(dst_stride) + c : int'(dst_base) + r * int'(width) + c;
        if (expand) sa = src_rect ? int'(src_base) + r * int'(src_stride) + c / 8 : int'(src_base) + r * sw + c / 8;
        else        sa = src_rect ? int'(src_base) + r * int'(src_stride) + c : int'(src_base) + r * int'(width) + c;
        s = exp_mem[sa];
        d = exp_mem[da];
        for (int l = 0; l < 2; l++) begin
          logic [7:0] p, o;
          bit en;
          if (expand) p = s[(c % 8) * 2 + l] ? col1 : col0;
          else        p = s[l*8 +: 8];
          o = rop[1] ? (p ^ d[l*8 +: 8]) : p;
          en = 1;
          if (c == 0 && !fbe[l]) en = 0;
          if (c == int'(width) - 1 && !lbe[l]) en = 0;
          if (rop[0] && p == 8'h00) en = 0;
          if (en) exp_mem[da][l*8 +: 8] = o;
        end
      end
    end
  endtask

  task automatic compare_mem(input string req);
    int bad_i;
    bad_i = -1;
    for (int i = 0; i < MEMN; i++)
      if (bad_i < 0 && tb_mem[i] !== exp_mem[i]) bad_i = i;
    if (bad_i < 0) chk(1, req, "memory", 0, 0);
    else chk(0, req, $sformatf("memory word %0d", bad_i), tb_mem[bad_i], exp_mem[bad_i]);
  endtask

  // start, wait for completion, check done timing and the transaction counts
  task automatic run_blit(input string req, input int exp_rd, input int exp_wr);
    int rd0, wr0, t;
    rd0 = n_rd; wr0 = n_wr;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R10", "done cleared by start", done, 0);
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R10", "done reached", done, 1);
    chk(busy == 1'b0 && cyc == last_wr_cyc + 1, "R10", "done one cycle after last write",
        cyc - last_wr_cyc, 1);
    chk(n_rd - rd0 == exp_rd, req, "read count", n_rd - rd0, exp_rd);
    chk(n_wr - wr0 == exp_wr, req, "write count", n_wr - wr0, exp_wr);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R10", "done held", done, 1);
    compare_mem(req);
  endtask

  task automatic setup(input int sb, input bit sr, input int ss, input int db, input bit dr,
                       input int ds, input int w, input int h, input int op, input bit ex,
                       input logic [1:0] fb, input logic [1:0] lb);
    src_base = AW'(sb); src_rect = sr; src_stride = AW'(ss);
    dst_base = AW'(db); dst_rect = dr; dst_stride = AW'(ds);
    width = DW'(w); height = DW'(h); rop = 2'(op); expand = ex;
    fbe = fb; lbe = lb;
    mem_init();
    model();
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
  endtask

  task automatic t_copy_rect_edges();   // R3 R4 R5
    setup(100, 1, 20, 400, 1, 32, 3, 2, 0, 0, 2'b10, 2'b01);
    run_blit("R3/R4/R5 copy rect", 6, 6);
  endtask

  task automatic t_width_one();         // R4 both masks
    setup(130, 1, 20, 450, 1, 32, 1, 3, 0, 0, 2'b10, 2'b11);
    run_blit("R4 width one", 3, 3);
  endtask

  task automatic t_linear();            // R2
    setup(150, 1, 16, 600, 0, 0, 4, 3, 0, 0, 2'b11, 2'b11);
    run_blit("R2 linear dst", 12, 12);
    setup(200, 0, 0, 700, 1, 24, 5, 2, 0, 0, 2'b11, 2'b11);
    run_blit("R2 linear src", 10, 10);
  endtask

  task automatic t_key();               // R6
    setup(300, 0, 0, 700, 1, 24, 5, 2, 1, 0, 2'b11, 2'b11);
    run_blit("R6 key", 10, 10);
  endtask

  task automatic t_xor();               // R7
    setup(100, 1, 20, 500, 1, 40, 3, 3, 2, 0, 2'b11, 2'b11);
    run_blit("R7 xor", 18, 9);
  endtask

  task automatic t_xor_key();           // R8
    setup(330, 0, 0, 520, 1, 40, 4, 2, 3, 0, 2'b01, 2'b11);
    run_blit("R8 xor key", 16, 8);
  endtask

  task automatic t_expand();            // R9
    col0 = 8'hA5; col1 = 8'h3C;
    setup(50, 0, 0, 800, 1, 16, 10, 2, 0, 1, 2'b11, 2'b11);
    run_blit("R9 expand", 4, 20);
    col0 = 8'h00; col1 = 8'h77;
    setup(60, 1, 5, 860, 1, 16, 8, 2, 1, 1, 2'b11, 2'b11);
    run_blit("R9 expand key", 2, 16);
  endtask

  task automatic t_zero();              // R12
    int rd0, wr0;
    rd0 = n_rd; wr0 = n_wr;
    width = 12'd4; height = 12'd0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R12", "zero height done", done, 1);
    width = 12'd0; height = 12'd3;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R12", "zero width done", done, 1);
    repeat (3) @(negedge clk);
    chk(n_rd == rd0 && n_wr == wr0, "R12", "no requests", n_rd + n_wr - rd0 - wr0, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    n_checks++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    col0 = 8'h00; col1 = 8'hFF;
    setup(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 2'b11, 2'b11);
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_copy_rect_edges();
    t_width_one();
    t_linear();
    t_key();
    t_xor();
    t_xor_key();
    t_expand();
    t_zero();
    chk(stall_err == 0, "R11", "request stable during stall", stall_err, 0);
    finish_run();
  end
endmodule